// File: doc/BRIEF.md
# Real-Time Clock Timekeeping Core

This block is the timekeeping core of a real-time clock. It lives entirely in the slow RTC clock domain. A programmable down-counting prescaler divides the RTC clock into a periodic time-base tick. A seconds counter advances by one on each tick. The counter is compared against an alarm value.

Three sticky event flags report a new second, a counter wrap and an alarm match. Each flag is raised one RTC cycle before the counter change it announces. Each flag can be masked onto a single interrupt line. The live prescaler remainder can be read at any time without disturbing the divider.

All register write strobes and values arrive already synchronised into the RTC domain. The surrounding bus bridge drives them. The only reset is the backup-domain reset `rst_ni`.

Top module: `rtc_core`

## Requirements
- R1: The prescaler remainder `div_o` counts down by one per cycle from the reload value to 0, then returns to the reload value. A tick happens on the cycle it leaves 0, so the tick period is reload+1 RTC cycles.
- R2: A reload write (`reload_we_i`) stores `reload_i` and restarts the prescaler. `div_o` equals the new value on the cycle after the write.
- R3: The counter increments by exactly one, wrapping modulo 2^CNT_W, one RTC cycle after each tick. The first increment after a prescaler restart comes reload+2 cycles after the restart.
- R4: A counter write is made with `cnt_hi_we_i` (upper half from `cnt_i`) and/or `cnt_lo_we_i` (lower half from `cnt_i`). It changes only the selected half or halves and also restarts the prescaler from the stored reload value.
- R5: Flag bit 0 (second) is set on each tick. It becomes visible one cycle before the counter increments.
- R6: Flag bit 1 (overflow) is set on the tick that precedes a wrap to zero. It is visible while `cnt_o` holds the all-ones value, one cycle before `cnt_o` becomes 0.
- R7: Flag bit 2 (alarm) is set, and `alarm_pulse_o` is high for exactly one cycle, when the counter has just reached the alarm value and a tick will carry it to alarm+1.
- R8: Flags are sticky. Setting bit i of `flag_clr_i` clears flag i on the next cycle, a same-cycle set wins, and clearing one flag leaves the others unchanged.
- R9: `irq_o` is the OR over the three sources of flag AND enable. Enables are written with `irq_en_we_i`/`irq_en_i`, using the same bit order as the flags.
- R10: After reset, the counter is 0, the flags, enables and interrupt are 0, the alarm is all ones, and the prescaler is loaded with parameter `RELOAD_RST`.
- R11: With a reload value of 0, a tick happens every RTC cycle and the counter advances every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | RTC clock |
| rst_ni | input | 1 | Backup-domain reset, active low, asynchronous |
| reload_i | input | PRE_W | New prescaler reload value |
| reload_we_i | input | 1 | Write strobe for reload value |
| cnt_i | input | CNT_W | New counter value |
| cnt_hi_we_i | input | 1 | Load upper counter half |
| cnt_lo_we_i | input | 1 | Load lower counter half |
| alarm_i | input | CNT_W | New alarm value |
| alarm_we_i | input | 1 | Write strobe for alarm value |
| irq_en_i | input | 3 | Interrupt enables (0 second, 1 overflow, 2 alarm) |
| irq_en_we_i | input | 1 | Write strobe for enables |
| flag_clr_i | input | 3 | Per-flag clear |
| cnt_o | output | CNT_W | Counter value |
| div_o | output | PRE_W | Live prescaler remainder |
| flags_o | output | 3 | Sticky flags (0 second, 1 overflow, 2 alarm) |
| alarm_pulse_o | output | 1 | One-cycle alarm pulse |
| irq_o | output | 1 | Masked interrupt request |

## Verification
Every reload value of a 4-bit prescaler is swept. For each one, the remainder and counter are compared cycle by cycle with values computed from the period reload+1. This separates an off-by-one period from a wrong restart point or a late counter step.

Reload 0 is run twice:
- Near the counter top, the overflow flag must appear exactly while the counter holds all ones.
- Just below an alarm value, the alarm flag and pulse must appear exactly while the counter equals the alarm.

In both runs the other enables are masked, so a flag that is set but not enabled must not reach the interrupt. Half-counter writes use distinct upper and lower nibbles to expose a half that is swapped or left unloaded.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned NUM_FLAGS = 3;
  localparam int unsigned FLG_SEC   = 0;
  localparam int unsigned FLG_OVF   = 1;
  localparam int unsigned FLG_ALM   = 2;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned PRE_W      = 20,
  parameter logic [PRE_W-1:0] RELOAD_RST = PRE_W'(32'h7FFF)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PRE_W-1:0] reload_i,
  input  logic             reload_we_i,
  input  logic             restart_i,
  output logic [PRE_W-1:0] div_o,
  output logic             tick_o
);
  logic [PRE_W-1:0] reload_q;
  logic [PRE_W-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) reload_q <= RELOAD_RST;
    else if (reload_we_i) reload_q <= reload_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               div_q <= RELOAD_RST;
    else if (reload_we_i)      div_q <= reload_i;
    else if (restart_i)        div_q <= reload_q;
    else if (div_q == '0)      div_q <= reload_q;
    else                       div_q <= div_q - 1'b1;
  end

  // a restart in the same cycle suppresses the tick
  assign tick_o = (div_q == '0) && !reload_we_i && !restart_i;
  assign div_o  = div_q;
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             hi_we_i,
  input  logic             lo_we_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_next_o
);
  localparam int unsigned HALF = CNT_W / 2;

  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;

  // increment is applied one cycle after the tick so flags lead the change
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= tick_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (hi_we_i || lo_we_i) begin
      if (hi_we_i) cnt_q[CNT_W-1:HALF] <= cnt_i[CNT_W-1:HALF];
      if (lo_we_i) cnt_q[HALF-1:0]     <= cnt_i[HALF-1:0];
    end else if (pend_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // value the counter holds once any pending increment has landed
  assign cnt_next_o = pend_q ? cnt_q + 1'b1 : cnt_q;
  assign cnt_o      = cnt_q;
endmodule

// File: rtl/rtc_flags.sv
module rtc_flags
  import rtc_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic [CNT_W-1:0]     cnt_next_i,
  input  logic [CNT_W-1:0]     alarm_i,
  input  logic                 alarm_we_i,
  input  logic [NUM_FLAGS-1:0] en_i,
  input  logic                 en_we_i,
  input  logic [NUM_FLAGS-1:0] clr_i,
  output logic [NUM_FLAGS-1:0] flags_o,
  output logic                 alarm_pulse_o,
  output logic                 irq_o
);
  logic [CNT_W-1:0]     alarm_q;
  logic [NUM_FLAGS-1:0] en_q;
  logic [NUM_FLAGS-1:0] flag_q;
  logic [NUM_FLAGS-1:0] set;
  logic                 pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alarm_q <= '1;
      en_q    <= '0;
    end else begin
      if (alarm_we_i) alarm_q <= alarm_i;
      if (en_we_i)    en_q    <= en_i;
    end
  end

  always_comb begin
    set          = '0;
    set[FLG_SEC] = tick_i;
    set[FLG_OVF] = tick_i && (cnt_next_i == '1);
    set[FLG_ALM] = tick_i && (cnt_next_i == alarm_q);
  end

  generate
    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       flag_q[i] <= 1'b0;
        else if (set[i])   flag_q[i] <= 1'b1;
        else if (clr_i[i]) flag_q[i] <= 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_q <= 1'b0;
    else         pulse_q <= set[FLG_ALM];
  end

  assign flags_o       = flag_q;
  assign alarm_pulse_o = pulse_q;
  assign irq_o         = |(flag_q & en_q);
endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_pkg::*;
#(
  parameter int unsigned PRE_W      = 20,
  parameter int unsigned CNT_W      = 32,
  parameter logic [PRE_W-1:0] RELOAD_RST = PRE_W'(32'h7FFF)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [PRE_W-1:0]     reload_i,
  input  logic                 reload_we_i,
  input  logic [CNT_W-1:0]     cnt_i,
  input  logic                 cnt_hi_we_i,
  input  logic                 cnt_lo_we_i,
  input  logic [CNT_W-1:0]     alarm_i,
  input  logic                 alarm_we_i,
  input  logic [NUM_FLAGS-1:0] irq_en_i,
  input  logic                 irq_en_we_i,
  input  logic [NUM_FLAGS-1:0] flag_clr_i,
  output logic [CNT_W-1:0]     cnt_o,
  output logic [PRE_W-1:0]     div_o,
  output logic [NUM_FLAGS-1:0] flags_o,
  output logic                 alarm_pulse_o,
  output logic                 irq_o
);
  logic             tick;
  logic [CNT_W-1:0] cnt_next;
  logic             cnt_we;

  assign cnt_we = cnt_hi_we_i | cnt_lo_we_i;

  rtc_prescaler #(.PRE_W(PRE_W), .RELOAD_RST(RELOAD_RST)) u_pre (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reload_i   (reload_i),
    .reload_we_i(reload_we_i),
    .restart_i  (cnt_we),
    .div_o      (div_o),
    .tick_o     (tick)
  );

  rtc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .cnt_i     (cnt_i),
    .hi_we_i   (cnt_hi_we_i),
    .lo_we_i   (cnt_lo_we_i),
    .cnt_o     (cnt_o),
    .cnt_next_o(cnt_next)
  );

  rtc_flags #(.CNT_W(CNT_W)) u_flg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick),
    .cnt_next_i   (cnt_next),
    .alarm_i      (alarm_i),
    .alarm_we_i   (alarm_we_i),
    .en_i         (irq_en_i),
    .en_we_i      (irq_en_we_i),
    .clr_i        (flag_clr_i),
    .flags_o      (flags_o),
    .alarm_pulse_o(alarm_pulse_o),
    .irq_o        (irq_o)
  );
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk #(
  parameter int unsigned PRE_W = 20,
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reload_we_i,
  input logic             cnt_hi_we_i,
  input logic             cnt_lo_we_i,
  input logic [2:0]       flag_clr_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic [PRE_W-1:0] div_o,
  input logic [2:0]       flags_o,
  input logic             alarm_pulse_o,
  input logic             irq_o
);
  logic past_valid;
  logic cnt_we;
  assign cnt_we = cnt_hi_we_i | cnt_lo_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_valid <= 1'b0;
    else         past_valid <= 1'b1;
  end

  assert_div_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_valid && ($past(div_o) != '0) && !$past(reload_we_i) && !$past(cnt_we)
    |-> div_o == PRE_W'($past(div_o) - 1'b1));

  assert_cnt_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_valid && !$stable(cnt_o) && !$past(cnt_we)
    |-> cnt_o == CNT_W'($past(cnt_o) + 1'b1));

  assert_sec_leads_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_valid && !$stable(cnt_o) && !$past(cnt_we) |-> $past(flags_o[0]));

  assert_pulse_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_pulse_o |-> flags_o[2]);

  assert_pulse_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_pulse_o |=> !alarm_pulse_o);

  assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_valid |-> ((($past(flags_o) & ~$past(flag_clr_i)) & ~flags_o) == 3'b000));

  assert_irq_src_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flags_o != 3'b000));
endmodule

bind rtc_core rtc_core_chk #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reload_we_i  (reload_we_i),
  .cnt_hi_we_i  (cnt_hi_we_i),
  .cnt_lo_we_i  (cnt_lo_we_i),
  .flag_clr_i   (flag_clr_i),
  .cnt_o        (cnt_o),
  .div_o        (div_o),
  .flags_o      (flags_o),
  .alarm_pulse_o(alarm_pulse_o),
  .irq_o        (irq_o)
);

// File: tb/sim_rtc_core.sv
module sim_rtc_core;
  localparam int unsigned PRE_W = 4;
  localparam int unsigned CNT_W = 8;
  localparam logic [PRE_W-1:0] RST_RELOAD = 4'd5;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [PRE_W-1:0] reload_i = '0;
  logic             reload_we_i = 1'b0;
  logic [CNT_W-1:0] cnt_i = '0;
  logic             cnt_hi_we_i = 1'b0;
  logic             cnt_lo_we_i = 1'b0;
  logic [CNT_W-1:0] alarm_i = '0;
  logic             alarm_we_i = 1'b0;
  logic [2:0]       irq_en_i = '0;
  logic             irq_en_we_i = 1'b0;
  logic [2:0]       flag_clr_i = '0;
  logic [CNT_W-1:0] cnt_o;
  logic [PRE_W-1:0] div_o;
  logic [2:0]       flags_o;
  logic             alarm_pulse_o;
  logic             irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  rtc_core #(.PRE_W(PRE_W), .CNT_W(CNT_W), .RELOAD_RST(RST_RELOAD)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .reload_i(reload_i), .reload_we_i(reload_we_i),
    .cnt_i(cnt_i), .cnt_hi_we_i(cnt_hi_we_i), .cnt_lo_we_i(cnt_lo_we_i),
    .alarm_i(alarm_i), .alarm_we_i(alarm_we_i),
    .irq_en_i(irq_en_i), .irq_en_we_i(irq_en_we_i), .flag_clr_i(flag_clr_i),
    .cnt_o(cnt_o), .div_o(div_o), .flags_o(flags_o),
    .alarm_pulse_o(alarm_pulse_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    reload_we_i = 0; cnt_hi_we_i = 0; cnt_lo_we_i = 0;
    alarm_we_i = 0; irq_en_we_i = 0; flag_clr_i = '0;
  endtask

  // fast-tick run: write counter, alarm and enables together, clear flags
  task automatic start_fast(input int c, input int a, input int en);
    @(negedge clk_i);
    reload_i = 0; reload_we_i = 1; cnt_i = CNT_W'(c);
    cnt_hi_we_i = 1; cnt_lo_we_i = 1;
    alarm_i = CNT_W'(a); alarm_we_i = 1;
    irq_en_i = 3'(en); irq_en_we_i = 1; flag_clr_i = 3'b111;
    @(negedge clk_i); idle();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R10 reset state
    check("R10 cnt", cnt_o, 0);
    check("R10 div", div_o, RST_RELOAD);
    check("R10 flags", flags_o, 0);
    check("R10 irq", irq_o, 0);
    rst_ni = 1;

    // R1 R2 R3 R5: sweep every reload value
    for (int r = 0; r < 16; r++) begin
      @(negedge clk_i);
      reload_i = PRE_W'(r); reload_we_i = 1; cnt_i = 0;
      cnt_hi_we_i = 1; cnt_lo_we_i = 1; flag_clr_i = 3'b111;
      @(negedge clk_i); idle();
      check("R2 div after reload", div_o, r);
      check("R4 cnt loaded", cnt_o, 0);
      for (int n = 1; n <= 2 * r + 3; n++) begin
        @(negedge clk_i);
        check("R1 remainder", div_o, (r - (n % (r + 1)) + r + 1) % (r + 1));
        check("R3 count", cnt_o, (n - 1) / (r + 1));
        check("R5 second flag", flags_o[0], (n >= r + 1) ? 1 : 0);
      end
    end

    // R6 R11: overflow with reload 0, only overflow enabled
    start_fast(8'hFD, 8'h40, 3'b010);
    for (int n = 1; n <= 5; n++) begin
      @(negedge clk_i);
      check("R11 fast count", cnt_o, (8'hFD + n - 1) % 256);
      check("R6 overflow flag", flags_o[1], (n >= 3) ? 1 : 0);
      check("R9 irq overflow only", irq_o, (n >= 3) ? 1 : 0);
    end

    // R7: alarm at 0x10, only alarm enabled
    start_fast(8'h0E, 8'h10, 3'b100);
    for (int n = 1; n <= 5; n++) begin
      @(negedge clk_i);
      check("R7 count", cnt_o, 8'h0E + n - 1);
      check("R7 alarm flag", flags_o[2], (n >= 3) ? 1 : 0);
      check("R7 alarm pulse", alarm_pulse_o, (n == 3) ? 1 : 0);
      check("R9 irq alarm only", irq_o, (n >= 3) ? 1 : 0);
      check("R6 no overflow", flags_o[1], 0);
    end

    // R8: stop fast ticks, then clear flags one at a time
    @(negedge clk_i); reload_i = 4'd15; reload_we_i = 1;
    @(negedge clk_i); idle();
    @(negedge clk_i);
    check("R8 sticky", flags_o, 3'b101);
    flag_clr_i = 3'b001;
    @(negedge clk_i); idle();
    check("R8 clear second only", flags_o, 3'b100);
    check("R9 irq kept", irq_o, 1);
    flag_clr_i = 3'b100;
    @(negedge clk_i); idle();
    check("R8 clear alarm", flags_o, 3'b000);
    check("R9 irq dropped", irq_o, 0);

    // R4: half writes
    cnt_i = 8'h3C; cnt_hi_we_i = 1; cnt_lo_we_i = 1;
    @(negedge clk_i); idle();
    check("R4 full write", cnt_o, 8'h3C);
    repeat (5) @(negedge clk_i);
    check("R1 div running", div_o, 10);
    cnt_i = 8'hA0; cnt_hi_we_i = 1;
    @(negedge clk_i); idle();
    check("R4 upper half", cnt_o, 8'hAC);
    check("R4 prescaler restart", div_o, 15);
    cnt_i = 8'h07; cnt_lo_we_i = 1;
    @(negedge clk_i); idle();
    check("R4 lower half", cnt_o, 8'hA7);

    // R10: reset in mid-run
    rst_ni = 0;
    @(negedge clk_i);
    check("R10 cnt after reset", cnt_o, 0);
    check("R10 div after reset", div_o, RST_RELOAD);
    check("R10 flags after reset", flags_o, 0);
    rst_ni = 1;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule